// File: doc/BRIEF.md
# UART Auto-Baud Detector

This block measures the bit time of an incoming asynchronous calibration character, the byte 0x55, on a serial receive line. It turns that measurement into a baud-rate divisor for the receiver's rate generator. Software arms the block with a one-cycle set pulse and selects one of four clock modes. The hardware then waits for the first rising edge after the start bit. While the line is being timed, the receive line gates a working counter: the counter does not sample the line. When the fifth rising edge arrives, at the end of the last data bit, the block stores the count, drops its enable and raises a done flag. A data-read strobe clears that flag, and the data returned by that read carries no meaning.

The counter advances once every eight base-rate periods. Over the eight measured bit periods the final count therefore equals one bit time in base-clock units. The counter is loaded with one on the first edge, so software subtracts one from the result for the best accuracy. While measurement runs, a hold output keeps the data receiver's state machine idle. A one-cycle clear pulse aborts the measurement: the stored divisor keeps its earlier value and no done flag is raised. A count that would pass all-ones saturates there and sets a sticky overflow flag. The next arming clears that flag.

The controller has three states. ST_IDLE moves to ST_ARMED on a set pulse. ST_ARMED moves to ST_MEASURE on the first synchronised rising edge, or back to ST_IDLE on a clear pulse. ST_MEASURE moves back to ST_IDLE either on a clear pulse (abort) or on the fifth rising edge (finish).

Top module: `autobaud_detector`

## Requirements
- R1: After reset, en, done, ovf and rx_hold are 0 and divisor is 0.
- R2: A set pulse while idle makes en and rx_hold 1 from the next cycle until the measurement finishes or is aborted.
- R3: For a clock mode whose measurement divisor is M (mode 2'b00 gives 512 system clocks, 2'b01 and 2'b10 give 128, 2'b11 gives 32), a 0x55 frame (low start bit, data sent LSB first, high stop bit) with bit time T leaves divisor minus one equal to floor(8*T/M), within one count.
- R4: On the fifth rising edge, counted from the first rising edge after arming, en falls to 0 and done rises to 1 in the same cycle.
- R5: A read strobe clears done on the next clock edge unless a measurement finishes in that same cycle.
- R6: A clear pulse during measurement returns en to 0, leaves divisor at its earlier value and raises no done.
- R7: A count that would pass the all-ones value of the counter width saturates there and sets ovf. The flag stays set until the next set pulse clears it.
- R8: The count starts at one, so a frame shorter than one measurement tick per eight bits gives divisor 1.
- R9: Rising edges on the line while en is 0 leave divisor and done unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | One-cycle pulse that arms a measurement |
| en_clr | input | 1 | One-cycle pulse that aborts a measurement |
| mode_sel | input | 2 | Clock mode: picks the measurement prescale |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| rd_strobe | input | 1 | Data-read strobe that clears done |
| en | output | 1 | Enable bit: set by software, cleared by hardware |
| rx_hold | output | 1 | Holds the data receiver's state machine idle |
| divisor | output | CNT_W | Stored measurement result |
| done | output | 1 | Measurement-complete flag |
| ovf | output | 1 | Sticky counter-saturation flag |

## Verification
en rises one clock edge after a set pulse, so the bench samples it a few cycles later. The final rising edge reaches the controller after two synchroniser stages and the edge register. done, divisor and the lowered en therefore appear on the third clock edge after the line goes high. The bench waits eight cycles after each frame before it checks these, and the scoreboard monitor compares divisor on the first falling edge at which done is seen high. A read strobe driven at a falling edge takes effect at the next rising edge, so done is checked at the falling edge that follows.

// File: rtl/abd_pkg.sv
package abd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_MEASURE = 2'd2
    } abd_state_t;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= rx_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/abd_prescaler.sv
module abd_prescaler #(
    parameter int BASE_SLOW = 64,
    parameter int BASE_MID  = 16,
    parameter int BASE_FAST = 4,
    parameter int OVS       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] mode,
    output logic       tick
);
    localparam int DIV_SLOW = BASE_SLOW * OVS;
    localparam int DIV_MID  = BASE_MID * OVS;
    localparam int DIV_FAST = BASE_FAST * OVS;
    localparam int PRE_W    = $clog2(DIV_SLOW);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        unique case (mode)
            2'b00:        lim = PRE_W'(DIV_SLOW - 1);
            2'b01, 2'b10: lim = PRE_W'(DIV_MID - 1);
            default:      lim = PRE_W'(DIV_FAST - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == lim);

    // R3: ticks are at least DIV_FAST cycles apart, never back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> !tick);
endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sat <= 1'b0;
        end else if (load) begin
            cnt <= CNT_W'(1);
            sat <= 1'b0;
        end else if (inc) begin
            if (cnt == CNT_MAX) begin
                sat <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: the count begins at one
    a_r8_start_one: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == CNT_W'(1)));

    // R7: an increment at the top value holds the value and marks saturation
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt == CNT_MAX) |=> (cnt == CNT_MAX && sat));
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
    import abd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BASE_SLOW = 64,
    parameter int BASE_MID  = 16,
    parameter int BASE_FAST = 4,
    parameter int OVS       = 8,
    parameter int EDGES     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [1:0]       mode_sel,
    input  logic             rx_in,
    input  logic             rd_strobe,
    output logic             en,
    output logic             rx_hold,
    output logic [CNT_W-1:0] divisor,
    output logic             done,
    output logic             ovf
);
    localparam int EC_W = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST_EC = EC_W'(EDGES - 2);

    abd_state_t       state_q, state_d;
    logic [EC_W-1:0]  edges_q;
    logic             rise, tick, load, finish, sat;
    logic [CNT_W-1:0] cnt;
    logic             done_q, ovf_q;
    logic [CNT_W-1:0] div_q;

    rx_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_in),
        .rise     (rise)
    );

    abd_prescaler #(
        .BASE_SLOW (BASE_SLOW),
        .BASE_MID  (BASE_MID),
        .BASE_FAST (BASE_FAST),
        .OVS       (OVS)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .run   (state_q == ST_MEASURE),
        .mode  (mode_sel),
        .tick  (tick)
    );

    abd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .inc   (tick),
        .cnt   (cnt),
        .sat   (sat)
    );

    assign load   = (state_q == ST_ARMED) && rise && !en_clr;
    assign finish = (state_q == ST_MEASURE) && rise && !en_clr && (edges_q == LAST_EC);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_set) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (en_clr)    state_d = ST_IDLE;
                else if (rise) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (en_clr)      state_d = ST_IDLE;
                else if (finish) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
            div_q   <= '0;
        end else begin
            if (load) begin
                edges_q <= '0;
            end else if (state_q == ST_MEASURE && rise) begin
                edges_q <= edges_q + 1'b1;
            end

            if (finish) begin
                done_q <= 1'b1;
            end else if (rd_strobe) begin
                done_q <= 1'b0;
            end

            if (state_q == ST_IDLE && en_set) begin
                ovf_q <= 1'b0;
            end else if (finish) begin
                ovf_q <= sat;
            end

            if (finish) begin
                div_q <= cnt;
            end
        end
    end

    assign en      = (state_q != ST_IDLE);
    assign rx_hold = en;
    assign divisor = div_q;
    assign done    = done_q;
    assign ovf     = ovf_q;

    // R2: arming takes effect on the next edge
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en_set) |=> (en && rx_hold));

    // R4: the final edge drops enable and raises done together
    a_r4_finish: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!en && done));

    // R5: a read clears done unless a finish collides with it
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !finish) |=> !done);

    // R6: an abort returns to idle with the stored result untouched
    a_r6_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && en) |=> (!en && $stable(divisor)));

    // R9: nothing moves the result while disabled
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !en_set) |=> $stable(divisor));

    // R7: a saturated result reads as all ones
    a_r7_ovf_value: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (divisor == '1));
endmodule

// File: tb/test_autobaud_detector.sv
`timescale 1ns/1ps
module test_autobaud_detector;
    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 1'b0;
    logic        en_clr = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        rx_in = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        en, rx_hold, done, ovf;
    logic [15:0] divisor;
    logic        n_en, n_hold, n_done, n_ovf;
    logic [NW-1:0] n_div;

    int checks = 0;
    int errors = 0;

    typedef struct { int k; string req; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    autobaud_detector i_autobaud_detector (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .mode_sel(mode_sel), .rx_in(rx_in), .rd_strobe(rd_strobe),
        .en(en), .rx_hold(rx_hold), .divisor(divisor), .done(done), .ovf(ovf)
    );

    autobaud_detector #(.CNT_W(NW)) i_autobaud_detector_narrow (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .mode_sel(mode_sel), .rx_in(rx_in), .rd_strobe(rd_strobe),
        .en(n_en), .rx_hold(n_hold), .divisor(n_div), .done(n_done), .ovf(n_ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int base_of(input logic [1:0] m);
        case (m)
            2'b00:   return 64;
            2'b11:   return 4;
            default: return 16;
        endcase
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set();
        en_set = 1'b1; @(negedge clk); en_set = 1'b0;
    endtask

    task automatic pulse_clr();
        en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
    endtask

    task automatic send_bits(input int t, input int first, input int last);
        for (int i = first; i <= last; i++) begin
            rx_in = (i == 0) ? 1'b0 : ((i == 9) ? 1'b1 : ((8'h55 >> (i - 1)) & 1));
            cycles(t);
        end
    endtask

    // driver: one armed measurement, expected result pushed into the scoreboard
    task automatic measure(input logic [1:0] m, input int k, input string req);
        int t;
        exp_t e;
        t = base_of(m) * k + base_of(m) / 2;
        mode_sel = m;
        pulse_set();
        cycles(2);
        check(en && rx_hold, "R2", int'(en), 1);
        e.k = k; e.req = req;
        sb_q.push_back(e);
        send_bits(t, 0, 9);
        cycles(8);
        check(!en, "R4", int'(en), 0);
        check(done, "R4", int'(done), 1);
        check(sb_q.size() == 0, "R4", sb_q.size(), 0);
    endtask

    task automatic read_clear();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        check(!done, "R5", int'(done), 0);
    endtask

    // monitor: compare the result when done first appears
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (done && !done_prev) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4", int'(divisor), -1);
            end else begin
                exp_t e;
                int diff;
                e = sb_q.pop_front();
                diff = int'(divisor) - 1 - e.k;
                check(diff >= -1 && diff <= 1, e.req, int'(divisor) - 1, e.k);
            end
        end
        done_prev = done;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] held;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        check(!en && !done && !ovf && !rx_hold, "R1", int'({en, done, ovf, rx_hold}), 0);
        check(divisor == 16'd0, "R1", int'(divisor), 0);

        // R3: all four clock modes at assorted bit times
        measure(2'b00, 20, "R3");
        read_clear();
        measure(2'b01, 40, "R3");
        read_clear();
        measure(2'b10, 7, "R3");
        read_clear();
        measure(2'b11, 100, "R3");
        check(!ovf, "R7", int'(ovf), 0);
        read_clear();

        // R8: shortest frame leaves exactly one
        measure(2'b11, 0, "R8");
        check(divisor == 16'd1, "R8", int'(divisor), 1);
        read_clear();

        // R7: narrow instance saturates while the wide one does not
        measure(2'b11, 80, "R3");
        check(n_div == '1, "R7", int'(n_div), (1 << NW) - 1);
        check(n_ovf, "R7", int'(n_ovf), 1);
        check(!ovf, "R7", int'(ovf), 0);
        read_clear();
        cycles(20);
        check(n_ovf, "R7", int'(n_ovf), 1);

        // R6: abort in the middle of a frame
        held = divisor;
        mode_sel = 2'b11;
        pulse_set();
        check(!n_ovf, "R7", int'(n_ovf), 0);
        send_bits(50, 0, 4);
        pulse_clr();
        cycles(1);
        check(!en, "R6", int'(en), 1'b0);
        check(divisor == held, "R6", int'(divisor), int'(held));
        send_bits(50, 5, 9);
        cycles(8);
        check(!done, "R6", int'(done), 0);
        check(divisor == held, "R6", int'(divisor), int'(held));

        // R9: a frame on the line while disabled
        send_bits(50, 0, 9);
        cycles(8);
        check(!done && !en, "R9", int'(done), 0);
        check(divisor == held, "R9", int'(divisor), int'(held));

        // R5: read strobe while nothing is pending keeps done low
        read_clear();
        check(sb_q.size() == 0, "R4", sb_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule